// File: doc/BRIEF.md
# DMA Completion Interrupt Generator

This block sits beside a pair of DMA data movers and consumes the status words they produce when a descriptor completes. One status stream comes from the read mover and one from the write mover. Each status word carries a descriptor ID, a 3-bit per-descriptor policy code and an error flag. From the policy code, the block decides in the cycle it accepts a word whether to forward that word to a status queue, drop it, or also raise an interrupt.

An interrupt is not a wire. The block builds an immediate-write descriptor from a programmed message address and message data, and pushes it into the write mover's descriptor queue. Each side has its own interrupt enable. When the policy asks for an interrupt but that side's enable is low, the block raises none.

All three data interfaces are valid/ready streams. A transfer happens on a cycle where valid and ready are both high. An output holds its valid and data steady until it is taken. An input is refused, with ready low, when any output slot it needs is full and is not draining in the same cycle. No status word or interrupt is ever lost. At most one status word is accepted per cycle, and the read side always wins.

Top module: `dma_irq_gen`

## Requirements
- R1: Policy code 3'b011 forwards the status word and generates one interrupt descriptor when that side's enable is high.
- R2: Policy code 3'b010 forwards the status word and generates an interrupt descriptor only when the error flag is 1 and that side's enable is high.
- R3: Policy code 3'b001 forwards the status word and never generates an interrupt.
- R4: Policy code 3'b000 discards the status word, so nothing appears on the status queue, and generates no interrupt.
- R5: Any policy code with bit 2 set forwards the status word and generates no interrupt.
- R6: A status word from the read side can only interrupt when `rd_irq_en` is 1, and one from the write side only when `wr_irq_en` is 1.
- R7: A generated descriptor carries the following fields. Destination is `msg_addr`. Payload is `msg_data`, zero-extended to 64 bits. Length is 1 dword. The immediate flag is set. Policy code is 3'b000. ID is the parameter `IRQ_ID`. Address and data are captured in the acceptance cycle.
- R8: When both inputs are valid, only the read side can be accepted, and `wr_sts_ready` is 0.
- R9: A side's ready is high exactly when the following holds. It is the chosen side. Its status word either needs no status-queue slot, or `sq_valid` is 0, or `sq_ready` is 1. Its status word either needs no interrupt, or `dq_valid` is 0, or `dq_ready` is 1. While an output is valid and not ready, its valid and data stay stable.
- R10: During and right after reset, `sq_valid` and `dq_valid` are 0.
- R11: A forwarded status word appears on the status queue one cycle after acceptance, with its ID, error flag, and `sq_from_wr` set to 1 for the write side and 0 for the read side. Forwarded words keep their acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_irq_en | input | 1 | Interrupt enable for read-side status |
| wr_irq_en | input | 1 | Interrupt enable for write-side status |
| msg_addr | input | ADDR_W | Interrupt message address |
| msg_data | input | DATA_W | Interrupt message data |
| rd_sts_valid | input | 1 | Read-side status valid |
| rd_sts_ready | output | 1 | Read-side status accepted |
| rd_sts_id | input | ID_W | Read-side descriptor ID |
| rd_sts_app | input | 3 | Read-side policy code |
| rd_sts_err | input | 1 | Read-side error flag |
| wr_sts_valid | input | 1 | Write-side status valid |
| wr_sts_ready | output | 1 | Write-side status accepted |
| wr_sts_id | input | ID_W | Write-side descriptor ID |
| wr_sts_app | input | 3 | Write-side policy code |
| wr_sts_err | input | 1 | Write-side error flag |
| sq_valid | output | 1 | Status queue entry valid |
| sq_ready | input | 1 | Status queue can take entry |
| sq_id | output | ID_W | Forwarded descriptor ID |
| sq_err | output | 1 | Forwarded error flag |
| sq_from_wr | output | 1 | 1 if from write side |
| dq_valid | output | 1 | Interrupt descriptor valid |
| dq_ready | input | 1 | Write mover queue can take descriptor |
| dq_id | output | ID_W | Descriptor ID (IRQ_ID) |
| dq_dst_addr | output | ADDR_W | Destination address |
| dq_payload | output | 64 | Immediate payload |
| dq_len | output | LEN_W | Length in dwords |
| dq_imm | output | 1 | Immediate-write flag |
| dq_app | output | 3 | Policy code of the generated descriptor |

## Verification
The bench uses the default parameters: 8-bit IDs, 64-bit address, 32-bit message data and an 18-bit length field. With these values all eight policy codes and both error values can be walked on both sides. Randomly throttled readiness on the two outputs keeps both single-entry slots full often, which exercises the refusal and drain-in-the-same-cycle paths. Enables and message values are re-randomised during the run. This shows that the captured descriptor fields belong to the acceptance cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int APP_W = 3;
  localparam logic [APP_W-1:0] APP_DROP     = 3'b000;
  localparam logic [APP_W-1:0] APP_KEEP     = 3'b001;
  localparam logic [APP_W-1:0] APP_IRQ_ERR  = 3'b010;
  localparam logic [APP_W-1:0] APP_IRQ_ALL  = 3'b011;

  typedef struct packed {
    logic keep;
    logic fire;
  } policy_t;
endpackage

// File: rtl/dma_irq_policy.sv
module dma_irq_policy
  import dma_irq_pkg::*;
(
  input  logic [APP_W-1:0] app,
  input  logic             err,
  input  logic             irq_en,
  output policy_t          pol
);
  always_comb begin
    pol.keep = 1'b1;
    pol.fire = 1'b0;
    unique case (app)
      APP_DROP:    pol.keep = 1'b0;
      APP_KEEP:    pol.fire = 1'b0;
      APP_IRQ_ERR: pol.fire = irq_en & err;
      APP_IRQ_ALL: pol.fire = irq_en;
      default:     pol.fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_irq_slot.sv
module dma_irq_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         can_load,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (can_load) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && can_load) out_data <= in_data;
  end
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
  import dma_irq_pkg::*;
#(
  parameter int          ID_W   = 8,
  parameter int          ADDR_W = 64,
  parameter int          DATA_W = 32,
  parameter int          LEN_W  = 18,
  parameter logic [ID_W-1:0] IRQ_ID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_irq_en,
  input  logic              wr_irq_en,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              rd_sts_valid,
  output logic              rd_sts_ready,
  input  logic [ID_W-1:0]   rd_sts_id,
  input  logic [APP_W-1:0]  rd_sts_app,
  input  logic              rd_sts_err,
  input  logic              wr_sts_valid,
  output logic              wr_sts_ready,
  input  logic [ID_W-1:0]   wr_sts_id,
  input  logic [APP_W-1:0]  wr_sts_app,
  input  logic              wr_sts_err,
  output logic              sq_valid,
  input  logic              sq_ready,
  output logic [ID_W-1:0]   sq_id,
  output logic              sq_err,
  output logic              sq_from_wr,
  output logic              dq_valid,
  input  logic              dq_ready,
  output logic [ID_W-1:0]   dq_id,
  output logic [ADDR_W-1:0] dq_dst_addr,
  output logic [63:0]       dq_payload,
  output logic [LEN_W-1:0]  dq_len,
  output logic              dq_imm,
  output logic [APP_W-1:0]  dq_app
);
  localparam int NSIDE = 2;
  localparam int PAY_W = 64;
  localparam int SQ_W  = ID_W + 2;
  localparam int DQ_W  = ADDR_W + PAY_W;

  logic [NSIDE-1:0]           s_valid, s_err, s_en, s_ok;
  logic [NSIDE-1:0][ID_W-1:0] s_id;
  logic [NSIDE-1:0][APP_W-1:0] s_app;
  policy_t [NSIDE-1:0]        s_pol;

  assign s_valid = {wr_sts_valid, rd_sts_valid};
  assign s_err   = {wr_sts_err,   rd_sts_err};
  assign s_en    = {wr_irq_en,    rd_irq_en};
  assign s_id    = {wr_sts_id,    rd_sts_id};
  assign s_app   = {wr_sts_app,   rd_sts_app};

  logic sq_can, dq_can;

  genvar gi;
  generate
    for (gi = 0; gi < NSIDE; gi++) begin : g_side
      dma_irq_policy u_pol (
        .app    (s_app[gi]),
        .err    (s_err[gi]),
        .irq_en (s_en[gi]),
        .pol    (s_pol[gi])
      );
      assign s_ok[gi] = (!s_pol[gi].keep || sq_can) && (!s_pol[gi].fire || dq_can);
    end
  endgenerate

  // Fixed priority: read side (index 0) first.
  logic sel;
  logic take;
  assign sel  = !s_valid[0];
  assign take = s_valid[sel] && s_ok[sel];

  assign rd_sts_ready = take && !sel;
  assign wr_sts_ready = take && sel;

  logic            sq_in_valid, dq_in_valid;
  logic [SQ_W-1:0] sq_in_data, sq_out_data;
  logic [DQ_W-1:0] dq_in_data, dq_out_data;

  assign sq_in_valid = take && s_pol[sel].keep;
  assign sq_in_data  = {s_id[sel], s_err[sel], sel};
  assign dq_in_valid = take && s_pol[sel].fire;
  assign dq_in_data  = {msg_addr, {(PAY_W-DATA_W){1'b0}}, msg_data};

  dma_irq_slot #(.W(SQ_W)) u_sq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (sq_in_valid),
    .in_data   (sq_in_data),
    .can_load  (sq_can),
    .out_valid (sq_valid),
    .out_data  (sq_out_data),
    .out_ready (sq_ready)
  );

  dma_irq_slot #(.W(DQ_W)) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dq_in_valid),
    .in_data   (dq_in_data),
    .can_load  (dq_can),
    .out_valid (dq_valid),
    .out_data  (dq_out_data),
    .out_ready (dq_ready)
  );

  assign {sq_id, sq_err, sq_from_wr} = sq_out_data;
  assign {dq_dst_addr, dq_payload}   = dq_out_data;
  assign dq_id  = IRQ_ID;
  assign dq_len = LEN_W'(1);
  assign dq_imm = 1'b1;
  assign dq_app = APP_DROP;
endmodule

// File: rtl/dma_irq_gen_chk.sv
module dma_irq_gen_chk #(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_irq_en,
  input logic              rd_sts_valid,
  input logic              rd_sts_ready,
  input logic [2:0]        rd_sts_app,
  input logic              wr_sts_ready,
  input logic              sq_valid,
  input logic              sq_ready,
  input logic [ID_W-1:0]   sq_id,
  input logic              dq_valid,
  input logic              dq_ready,
  input logic [ADDR_W-1:0] dq_dst_addr,
  input logic [63:0]       dq_payload
);
  AST_RD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts_valid |-> !wr_sts_ready); // R8

  AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid && !sq_ready |=> sq_valid && $stable(sq_id)); // R9

  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && !dq_ready |=> dq_valid && $stable(dq_dst_addr) && $stable(dq_payload)); // R9

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts_valid && rd_sts_ready && rd_sts_app == 3'b000 && (!sq_valid || sq_ready)
    |=> !sq_valid); // R4

  AST_RD_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts_valid && rd_sts_ready && !rd_irq_en && (!dq_valid || dq_ready)
    |=> !dq_valid); // R6

  AST_KEEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts_valid && rd_sts_ready && rd_sts_app == 3'b001 |=> sq_valid); // R3
endmodule

bind dma_irq_gen dma_irq_gen_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_irq_en    (rd_irq_en),
  .rd_sts_valid (rd_sts_valid),
  .rd_sts_ready (rd_sts_ready),
  .rd_sts_app   (rd_sts_app),
  .wr_sts_ready (wr_sts_ready),
  .sq_valid     (sq_valid),
  .sq_ready     (sq_ready),
  .sq_id        (sq_id),
  .dq_valid     (dq_valid),
  .dq_ready     (dq_ready),
  .dq_dst_addr  (dq_dst_addr),
  .dq_payload   (dq_payload)
);

// File: tb/dma_irq_gen_tb.sv
module dma_irq_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_irq_en = 0, wr_irq_en = 0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        rd_sts_valid = 0, wr_sts_valid = 0;
  logic        rd_sts_ready, wr_sts_ready;
  logic [7:0]  rd_sts_id = '0, wr_sts_id = '0;
  logic [2:0]  rd_sts_app = '0, wr_sts_app = '0;
  logic        rd_sts_err = 0, wr_sts_err = 0;
  logic        sq_valid, sq_ready = 0, sq_err, sq_from_wr;
  logic [7:0]  sq_id;
  logic        dq_valid, dq_ready = 0, dq_imm;
  logic [7:0]  dq_id;
  logic [63:0] dq_dst_addr, dq_payload;
  logic [17:0] dq_len;
  logic [2:0]  dq_app;

  always #4 clk = ~clk;

  dma_irq_gen u_dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [9:0]   exp_sq[$];
  logic [127:0] exp_dq[$];

  function automatic logic keeps(input logic [2:0] app);
    return app != 3'b000;
  endfunction
  function automatic logic fires(input logic [2:0] app, input logic err, input logic en);
    if (!en) return 1'b0;
    if (app == 3'b011) return 1'b1;
    if (app == 3'b010) return err;
    return 1'b0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Evaluate one cycle: call after inputs are settled, before the next posedge.
  task automatic eval_cycle;
    logic sqc, dqc, okr, okw, er, ew;
    logic [127:0] e;
    if (sq_valid && sq_ready) begin
      if (exp_sq.size() == 0) chk(1'b0, "R4/R11 unexpected status", {118'd0, sq_id, sq_err, sq_from_wr}, '0);
      else begin
        e = {118'd0, exp_sq.pop_front()};
        chk({sq_id, sq_err, sq_from_wr} == e[9:0], "R11 status word", {118'd0, sq_id, sq_err, sq_from_wr}, e);
      end
    end
    if (dq_valid && dq_ready) begin
      chk(dq_len == 18'd1 && dq_imm && dq_app == 3'b000 && dq_id == 8'hFF, "R7 fixed fields",
          {dq_id, dq_app, dq_imm, dq_len}, {8'hFF, 3'b000, 1'b1, 18'd1});
      if (exp_dq.size() == 0) chk(1'b0, "R1/R2/R5/R6 unexpected interrupt", {dq_dst_addr, dq_payload}, '0);
      else begin
        e = exp_dq.pop_front();
        chk({dq_dst_addr, dq_payload} == e, "R7 descriptor", {dq_dst_addr, dq_payload}, e);
      end
    end
    sqc = !sq_valid || sq_ready;
    dqc = !dq_valid || dq_ready;
    okr = (!keeps(rd_sts_app) || sqc) && (!fires(rd_sts_app, rd_sts_err, rd_irq_en) || dqc);
    okw = (!keeps(wr_sts_app) || sqc) && (!fires(wr_sts_app, wr_sts_err, wr_irq_en) || dqc);
    er = rd_sts_valid && okr;
    ew = !rd_sts_valid && wr_sts_valid && okw;
    chk(rd_sts_ready == er, "R9 read ready", {127'd0, rd_sts_ready}, {127'd0, er});
    chk(wr_sts_ready == ew, rd_sts_valid ? "R8 write ready" : "R9 write ready",
        {127'd0, wr_sts_ready}, {127'd0, ew});
    if (rd_sts_valid && rd_sts_ready) begin
      if (keeps(rd_sts_app)) exp_sq.push_back({rd_sts_id, rd_sts_err, 1'b0});
      if (fires(rd_sts_app, rd_sts_err, rd_irq_en)) exp_dq.push_back({msg_addr, 32'd0, msg_data});
    end else if (wr_sts_valid && wr_sts_ready) begin
      if (keeps(wr_sts_app)) exp_sq.push_back({wr_sts_id, wr_sts_err, 1'b1});
      if (fires(wr_sts_app, wr_sts_err, wr_irq_en)) exp_dq.push_back({msg_addr, 32'd0, msg_data});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!sq_valid && !dq_valid, "R10 reset outputs", {126'd0, sq_valid, dq_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sq_valid && !dq_valid, "R10 after reset", {126'd0, sq_valid, dq_valid}, '0);
    msg_addr = 64'hFEE0_0000_0000_1000;
    msg_data = 32'hA5A5_0042;
    // Directed: every policy code and error value, read side enabled, write side disabled.
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 16; k++) begin
        rd_irq_en = 1'b1; wr_irq_en = 1'b0;
        sq_ready = 1'b1; dq_ready = 1'b1;
        rd_sts_valid = (s == 0); wr_sts_valid = (s == 1);
        rd_sts_app = k[3:1]; wr_sts_app = k[3:1];
        rd_sts_err = k[0];   wr_sts_err = k[0];
        rd_sts_id = 8'(k);   wr_sts_id = 8'(k + 16);
        #1; eval_cycle();
        @(negedge clk);
      end
    end
    // Directed: both sides valid with full, stalled outputs.
    rd_sts_valid = 1'b1; wr_sts_valid = 1'b1;
    rd_sts_app = 3'b011; wr_sts_app = 3'b011; rd_irq_en = 1'b1; wr_irq_en = 1'b1;
    sq_ready = 1'b0; dq_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1; eval_cycle();
      @(negedge clk);
    end
    // Random phase.
    for (int c = 0; c < 4000; c++) begin
      rd_sts_valid = ($urandom % 100) < 55;
      wr_sts_valid = ($urandom % 100) < 55;
      rd_sts_app = 3'($urandom); wr_sts_app = 3'($urandom);
      rd_sts_err = 1'($urandom); wr_sts_err = 1'($urandom);
      rd_sts_id = 8'($urandom); wr_sts_id = 8'($urandom);
      sq_ready = ($urandom % 100) < 65;
      dq_ready = ($urandom % 100) < 65;
      if ($urandom % 50 == 0) begin
        rd_irq_en = 1'($urandom); wr_irq_en = 1'($urandom);
        msg_addr = {$urandom, $urandom}; msg_data = $urandom;
      end
      #1; eval_cycle();
      @(negedge clk);
    end
    // Drain.
    rd_sts_valid = 1'b0; wr_sts_valid = 1'b0; sq_ready = 1'b1; dq_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #1; eval_cycle();
      @(negedge clk);
    end
    chk(exp_sq.size() == 0, "R3 R11 status lost", {96'd0, 32'(exp_sq.size())}, '0);
    chk(exp_dq.size() == 0, "R1 R2 interrupt lost", {96'd0, 32'(exp_dq.size())}, '0);
    finish_run();
  end
endmodule